// File: doc/BRIEF.md
# Multi-Input Elastic Join

This block sits in front of a consumer stage that needs one item from each of several producer channels before it can act. Every channel uses a valid/stop handshake: a producer raises valid and holds its data steady, and an item moves on a cycle where valid is high and the returned stop is low. The join presents one combined channel to the consumer. That channel is valid only once every producer is valid, and it carries all producer data side by side.

Going upstream, the join returns a stop to each producer. A producer that is ready early is held until its siblings catch up. A stall from the consumer reaches every producer. The block is purely combinational and holds no data. Every producer item in a tuple is therefore consumed in the same cycle, and the tuples leave in the order the producers offered them. The number of producers and the data width are parameters, and the number of producers must be at least 2.

Top module: `elastic_join`

## Requirements
- R1: `cons_valid` is high exactly when every bit of `prod_valid` is high, in the same cycle.
- R2: While `cons_stop` is high, every bit of `prod_stop` is high, whatever the producer valids are.
- R3: A producer whose valid is high while at least one other producer's valid is low receives stop high.
- R4: When all producers are valid and `cons_stop` is low, every bit of `prod_stop` is low.
- R5: While `cons_stop` is low, a producer whose valid is low receives stop low.
- R6: Lane i of `cons_data` (bits i*WIDTH up to i*WIDTH+WIDTH-1) equals lane i of `prod_data` in the same cycle. Lane 0 is the least significant.
- R7: A producer transfer (valid high, stop low) happens on exactly the cycles where `cons_valid` is high and `cons_stop` is low. Under any arrival timing and any consumer stalls, each tuple is therefore delivered complete, once, and in producer order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| prod_valid | input | LANES | Valid flag of each producer, bit i for producer i |
| prod_data | input | LANES*WIDTH | Producer data, lane i in bits i*WIDTH up to i*WIDTH+WIDTH-1 |
| prod_stop | output | LANES | Stop returned to each producer |
| cons_valid | output | 1 | Combined valid offered to the consumer |
| cons_data | output | LANES*WIDTH | Combined data offered to the consumer |
| cons_stop | input | 1 | Stall request from the consumer |

## Verification
The bench goes after lanes that arrive early while a sibling is missing. A join that failed to hold such a lane would let it transfer alone, and the next tuple would pair with stale siblings. A consumer stall that coincides with a partial arrival, and one that arrives while every lane is idle, expose a join that misses the broadcast or that stalls idle producers. Long random runs with skewed arrivals then compare every delivered tuple with the expected sequence, so a swapped lane, a dropped item or a duplicated item shows up as a data mismatch or as a leftover expected entry.

// File: rtl/ejoin_pkg.sv
package ejoin_pkg;

    localparam int unsigned EJ_MIN_LANES = 2;

    // Situation of one producer lane within the current cycle
    typedef enum logic [2:0] {
        LANE_IDLE    = 3'd0,  // not valid, consumer free
        LANE_BLOCKED = 3'd1,  // not valid, consumer stalled
        LANE_EARLY   = 3'd2,  // valid, some sibling missing
        LANE_HELD    = 3'd3,  // valid, siblings present, consumer stalled
        LANE_GO      = 3'd4   // valid, tuple complete, consumer free
    } lane_state_e;

    function automatic lane_state_e lane_classify(
        input logic valid,
        input logic peers_ok,
        input logic down_stop
    );
        lane_state_e s;
        if (!valid)
            s = down_stop ? LANE_BLOCKED : LANE_IDLE;
        else if (!peers_ok)
            s = LANE_EARLY;
        else if (down_stop)
            s = LANE_HELD;
        else
            s = LANE_GO;
        return s;
    endfunction

    function automatic logic lane_must_wait(input lane_state_e s);
        return (s == LANE_BLOCKED) || (s == LANE_EARLY) || (s == LANE_HELD);
    endfunction

endpackage

// File: rtl/ejoin_peer_and.sv
module ejoin_peer_and #(
    parameter int unsigned LANES = 3
) (
    input  logic [LANES-1:0] lane_v,
    output logic             all_v,
    output logic [LANES-1:0] peers_ok
);
    // prefix and suffix AND chains: peers_ok[i] excludes lane i itself
    logic [LANES:0] pre_and;
    logic [LANES:0] suf_and;

    assign pre_and[0]     = 1'b1;
    assign suf_and[LANES] = 1'b1;

    for (genvar g = 0; g < LANES; g++) begin : g_chain
        assign pre_and[g+1] = pre_and[g] & lane_v[g];
        assign suf_and[g]   = suf_and[g+1] & lane_v[g];
        assign peers_ok[g]  = pre_and[g] & suf_and[g+1];
    end

    assign all_v = pre_and[LANES];

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            AST_PEER_EXCLUDES_SELF: assert (!(lane_v[i] && peers_ok[i]) || all_v)
                else $error("peer term disagrees with full AND on lane %0d", i); // R3
        end
    end
endmodule

// File: rtl/ejoin_lane_ctrl.sv
module ejoin_lane_ctrl
    import ejoin_pkg::*;
#(
    parameter int unsigned LANES = 3
) (
    input  logic [LANES-1:0] lane_v,
    input  logic [LANES-1:0] peers_ok,
    input  logic             down_stop,
    output logic [LANES-1:0] lane_stop,
    output logic [LANES-1:0] lane_go
);
    lane_state_e lane_st [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_st[g]   = lane_classify(lane_v[g], peers_ok[g], down_stop);
        assign lane_stop[g] = lane_must_wait(lane_st[g]);
        assign lane_go[g]   = (lane_st[g] == LANE_GO);
    end

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            AST_GO_NOT_STOPPED: assert (!(lane_go[i] && lane_stop[i]))
                else $error("lane %0d both moving and stopped", i); // R4
        end
    end
endmodule

// File: rtl/ejoin_data_route.sv
module ejoin_data_route #(
    parameter int unsigned LANES = 3,
    parameter int unsigned WIDTH = 8
) (
    input  logic [LANES*WIDTH-1:0] in_data,
    output logic [LANES*WIDTH-1:0] out_data
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign out_data[g*WIDTH +: WIDTH] = in_data[g*WIDTH +: WIDTH];
    end
endmodule

// File: rtl/elastic_join.sv
module elastic_join
    import ejoin_pkg::*;
#(
    parameter int unsigned LANES = 3,
    parameter int unsigned WIDTH = 8
) (
    input  logic [LANES-1:0]       prod_valid,
    input  logic [LANES*WIDTH-1:0] prod_data,
    output logic [LANES-1:0]       prod_stop,
    output logic                   cons_valid,
    output logic [LANES*WIDTH-1:0] cons_data,
    input  logic                   cons_stop
);
    localparam logic [LANES-1:0] ALL_ONES = {LANES{1'b1}};

    logic [LANES-1:0] peers_ok;
    logic [LANES-1:0] lane_go;

    if (LANES < EJ_MIN_LANES) begin : g_bad_lanes
        $error("elastic_join needs at least two lanes");
    end

    ejoin_peer_and #(.LANES(LANES)) u_peer (
        .lane_v   (prod_valid),
        .all_v    (cons_valid),
        .peers_ok (peers_ok)
    );

    ejoin_lane_ctrl #(.LANES(LANES)) u_ctrl (
        .lane_v    (prod_valid),
        .peers_ok  (peers_ok),
        .down_stop (cons_stop),
        .lane_stop (prod_stop),
        .lane_go   (lane_go)
    );

    ejoin_data_route #(.LANES(LANES), .WIDTH(WIDTH)) u_route (
        .in_data  (prod_data),
        .out_data (cons_data)
    );

    always_comb begin
        AST_JOIN_VALID: assert (cons_valid == (prod_valid == ALL_ONES))
            else $error("combined valid wrong"); // R1
        AST_STOP_BROADCAST: assert (!cons_stop || (prod_stop == ALL_ONES))
            else $error("consumer stall not broadcast"); // R2
        AST_ALL_GO: assert (!(cons_valid && !cons_stop) || (prod_stop == '0 && lane_go == ALL_ONES))
            else $error("complete tuple not released"); // R4
        AST_IDLE_FREE: assert (cons_stop || ((prod_stop & ~prod_valid) == '0))
            else $error("idle producer stalled"); // R5
        AST_ONE_TRANSFER: assert (((prod_valid & ~prod_stop) == '0) || (cons_valid && !cons_stop))
            else $error("partial transfer"); // R7
        for (int i = 0; i < LANES; i++) begin
            AST_EARLY_HELD: assert (!(prod_valid[i] && !cons_valid) || prod_stop[i])
                else $error("early lane %0d not held", i); // R3
        end
    end
endmodule

// File: tb/tb_elastic_join.sv
module tb_elastic_join;
    localparam int LANES      = 3;
    localparam int WIDTH      = 8;
    localparam int CLK_PERIOD = 10;
    localparam int NTUP       = 300;
    localparam int WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [LANES-1:0]       prod_valid;
    logic [LANES*WIDTH-1:0] prod_data;
    logic [LANES-1:0]       prod_stop;
    logic                   cons_valid;
    logic [LANES*WIDTH-1:0] cons_data;
    logic                   cons_stop;

    elastic_join #(.LANES(LANES), .WIDTH(WIDTH)) dut (
        .prod_valid (prod_valid),
        .prod_data  (prod_data),
        .prod_stop  (prod_stop),
        .cons_valid (cons_valid),
        .cons_data  (cons_data),
        .cons_stop  (cons_stop)
    );

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;
    logic [LANES*WIDTH-1:0] exp_q[$];

    function automatic logic [WIDTH-1:0] lane_val(input int lane, input int k);
        return WIDTH'((k * 7 + lane * 29 + 3) & 255);
    endfunction

    function automatic logic [LANES*WIDTH-1:0] tuple_of(input int k);
        logic [LANES*WIDTH-1:0] t;
        for (int i = 0; i < LANES; i++) t[i*WIDTH +: WIDTH] = lane_val(i, k);
        return t;
    endfunction

    task automatic push_expected(input int k);
        exp_q.push_back(tuple_of(k));
    endtask

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [LANES-1:0] model_stop(input logic [LANES-1:0] v, input logic cs);
        logic [LANES-1:0] s;
        for (int i = 0; i < LANES; i++) begin
            logic others = 1'b1;
            for (int j = 0; j < LANES; j++) if (j != i) others &= v[j];
            s[i] = cs | (v[i] & ~others);
        end
        return s;
    endfunction

    task automatic directed(input logic [LANES-1:0] v, input logic cs, input string req);
        @(posedge clk); #1;
        prod_valid = v;
        cons_stop  = cs;
        @(negedge clk);
        check(64'(cons_valid), 64'(v == {LANES{1'b1}}), {req, " R1 valid"});
        check(64'(prod_stop), 64'(model_stop(v, cs)), {req, " stop"});
    endtask

    // watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int seq [LANES];
        logic [LANES-1:0] pv;
        int delivered;
        prod_valid = '0;
        prod_data  = tuple_of(5);
        cons_stop  = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // reset/idle state
        @(negedge clk);
        check(64'(cons_valid), 64'd0, "R1 idle valid");
        check(64'(prod_stop), 64'd0, "R5 idle stop");
        check(64'(cons_data), 64'(tuple_of(5)), "R6 passthrough");

        directed(3'b101, 1'b0, "R3 early lanes held");
        directed(3'b010, 1'b0, "R3/R5 single early");
        directed(3'b111, 1'b0, "R4 all go");
        check(64'(prod_stop), 64'd0, "R4 no stop");
        directed(3'b111, 1'b1, "R2 stall full");
        directed(3'b000, 1'b1, "R2 stall idle");
        directed(3'b011, 1'b1, "R2 stall partial");
        for (int c = 0; c < 16; c++) begin
            directed(c[2:0], c[3], "R3/R5 sweep");
        end
        prod_data = tuple_of(77);
        @(negedge clk);
        check(64'(cons_data), 64'(tuple_of(77)), "R6 passthrough 2");

        // random phase
        for (int k = 0; k < NTUP; k++) push_expected(k);
        for (int i = 0; i < LANES; i++) seq[i] = 0;
        pv = '0;
        delivered = 0;
        while (delivered < NTUP) begin
            logic acc;
            @(posedge clk); #1;
            for (int i = 0; i < LANES; i++) begin
                if (!pv[i] && seq[i] < NTUP && $urandom_range(0, 2) != 0) pv[i] = 1'b1;
                prod_data[i*WIDTH +: WIDTH] = lane_val(i, seq[i]);
            end
            prod_valid = pv;
            cons_stop  = ($urandom_range(0, 3) == 0);
            @(negedge clk);
            acc = cons_valid & ~cons_stop;
            if (acc) begin
                if (exp_q.size() == 0) begin
                    check(64'd1, 64'd0, "R7 extra tuple");
                end else begin
                    logic [LANES*WIDTH-1:0] e;
                    e = exp_q.pop_front();
                    check(64'(cons_data), 64'(e), "R7 tuple order");
                end
                delivered++;
            end
            for (int i = 0; i < LANES; i++) begin
                logic fire;
                fire = pv[i] & ~prod_stop[i];
                check(64'(fire), 64'(acc), "R7 joint transfer");
                if (fire) begin
                    seq[i]++;
                    pv[i] = 1'b0;
                end
            end
        end
        check(64'(exp_q.size()), 64'd0, "R7 all delivered");
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule